// File: doc/BRIEF.md
# Tiled Pixel Fetch and Palette Lookup

This block turns a pixel position inside one square tile into a colour. Each request carries a tile base address in video memory, a column and row within the tile, a pixel format flag, a palette bank and a palette region offset. The block first reads one byte of video memory and takes a palette index from it. It then reads one halfword of palette memory and returns a 15-bit colour. Results whose index means "no pixel" are flagged as transparent.

Two pixel formats are supported. In the packed format each byte holds two 4-bit indices, so a tile row takes half as many bytes as it has pixels. In the byte format each byte is a full 8-bit index, and a row takes one byte per pixel. Both memories are external and have synchronous read ports: an address presented in one cycle returns its data in the next. The lookup is a two-stage pipeline that accepts one request per cycle. Transparent results make no palette read, but they arrive at the same time as coloured ones.

Top module: `tile_pixel_lookup`

## Requirements
- R1: After reset, outValid, vramRdEn and palRdEn are 0 until a request is made.
- R2: A request accepted on one clock edge gives outValid=1 during the cycle after the second edge. Requests on consecutive cycles produce results on consecutive cycles, in order.
- R3: Packed format (reqFormat=0): vramRdAddr = reqBase + reqY*(TILE/2) + floor(reqX/2). With the default 8x8 tile this is reqBase + 4*reqY + reqX/2. The address is presented in the same cycle as reqValid.
- R4: Packed format: an even reqX selects bits [3:0] of the video byte as the index, and an odd reqX selects bits [7:4].
- R5: Byte format (reqFormat=1): vramRdAddr = reqBase + reqY*TILE + reqX, and the whole byte is the index.
- R6: For a non-transparent index, palRdAddr = reqRegion + 2*index + 32*reqBank, taken modulo 2^PAL_AW. It is presented with palRdEn=1 in the cycle after the request.
- R7: An index of 0 gives outTransparent=1 and outColour=0, and no palette read is made for it (palRdEn stays 0).
- R8: When reqBank is non-zero, an index whose low four bits are 0 is also transparent. With bank 0, a non-zero index that is a multiple of 16 is coloured.
- R9: For a coloured result, outColour equals bits [14:0] of the palette halfword. Bit 15 has no effect on the output.
- R10: With reqValid=0, no video read is made (vramRdEn=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqBase | input | VRAM_AW | Tile base byte address in video memory |
| reqX | input | COORD_W | Column within the tile |
| reqY | input | COORD_W | Row within the tile |
| reqFormat | input | 1 | 0 = packed 4-bit indices, 1 = 8-bit indices |
| reqBank | input | BANK_W | Palette bank |
| reqRegion | input | PAL_AW | Palette region byte offset |
| vramRdEn | output | 1 | Video memory read strobe |
| vramRdAddr | output | VRAM_AW | Video memory byte address |
| vramRdData | input | 8 | Video memory byte, one cycle after the strobe |
| palRdEn | output | 1 | Palette memory read strobe |
| palRdAddr | output | PAL_AW | Palette halfword byte address |
| palRdData | input | 16 | Palette halfword, one cycle after the strobe |
| outValid | output | 1 | Result present |
| outColour | output | 15 | Resolved colour, 0 when transparent |
| outTransparent | output | 1 | Result is transparent |

## Verification
Each result has a known due time. The video address appears combinationally in the same cycle as the request. The palette strobe and address follow one cycle later. The colour, the transparency flag and the valid bit appear in the cycle after the second rising edge. The bench drives every request on a falling edge and samples each of these three results on falling edges at exactly those offsets: the video address 1 ns after driving, the palette port one falling edge later, and the result two falling edges later. In the back-to-back run, the bench checks the output for request n at the same falling edge where it drives request n+2. A trailing idle cycle confirms that outValid drops when no request follows.

// File: rtl/tpl_pkg.sv
package tpl_pkg;

  typedef enum logic {
    FMT_NIBBLE = 1'b0,
    FMT_BYTE   = 1'b1
  } tpl_fmt_e;

  typedef struct packed {
    logic loadReq;
    logic loadLookup;
    logic fetchPal;
  } tpl_strobe_t;

endpackage

// File: rtl/tpl_ctrl.sv
module tpl_ctrl
  import tpl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reqValid,
  input  logic        s1Transp,
  output tpl_strobe_t strobe,
  output logic        vramRdEn,
  output logic        palRdEn,
  output logic        outValid
);

  logic s1Valid;
  logic s2Valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1Valid <= 1'b0;
      s2Valid <= 1'b0;
    end else begin
      s1Valid <= reqValid;
      s2Valid <= s1Valid;
    end
  end

  always_comb begin
    strobe.loadReq    = reqValid;
    strobe.loadLookup = s1Valid;
    strobe.fetchPal   = s1Valid & ~s1Transp;
  end

  assign vramRdEn = reqValid;
  assign palRdEn  = strobe.fetchPal;
  assign outValid = s2Valid;

endmodule

// File: rtl/tpl_datapath.sv
module tpl_datapath
  import tpl_pkg::*;
#(
  parameter int VRAM_AW  = 17,
  parameter int PAL_AW   = 10,
  parameter int COORD_W  = 3,
  parameter int BANK_W   = 4,
  parameter int COLOUR_W = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  tpl_strobe_t         strobe,
  input  logic [VRAM_AW-1:0]  reqBase,
  input  logic [COORD_W-1:0]  reqX,
  input  logic [COORD_W-1:0]  reqY,
  input  logic                reqFormat,
  input  logic [BANK_W-1:0]   reqBank,
  input  logic [PAL_AW-1:0]   reqRegion,
  output logic [VRAM_AW-1:0]  vramRdAddr,
  input  logic [7:0]          vramRdData,
  output logic [PAL_AW-1:0]   palRdAddr,
  input  logic [15:0]         palRdData,
  output logic                s1Transp,
  input  logic                resValid,
  output logic [COLOUR_W-1:0] outColour,
  output logic                outTransparent
);

  localparam int NIB_ROW_SH  = COORD_W - 1;
  localparam int BYTE_ROW_SH = COORD_W;
  localparam int IDX_SH      = 1;
  localparam int BANK_SH     = 5;

  logic [VRAM_AW-1:0] rowNib, rowByte, colNib, colByte;
  logic [PAL_AW-1:0]  idxOff, bankOff;
  logic               s1OddX;
  tpl_fmt_e           s1Fmt;
  logic [BANK_W-1:0]  s1Bank;
  logic [PAL_AW-1:0]  s1Region;
  logic [7:0]         s1Index;
  logic               s2Transp;

  // stage 0: byte address, shift amounts derived from tile geometry
  always_comb begin
    rowNib     = VRAM_AW'(reqY) << NIB_ROW_SH;
    rowByte    = VRAM_AW'(reqY) << BYTE_ROW_SH;
    colNib     = VRAM_AW'(reqX >> 1);
    colByte    = VRAM_AW'(reqX);
    vramRdAddr = (tpl_fmt_e'(reqFormat) == FMT_BYTE)
               ? reqBase + rowByte + colByte
               : reqBase + rowNib + colNib;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1OddX   <= 1'b0;
      s1Fmt    <= FMT_NIBBLE;
      s1Bank   <= '0;
      s1Region <= '0;
    end else if (strobe.loadReq) begin
      s1OddX   <= reqX[0];
      s1Fmt    <= tpl_fmt_e'(reqFormat);
      s1Bank   <= reqBank;
      s1Region <= reqRegion;
    end
  end

  // stage 1: index extraction, transparency, palette address
  always_comb begin
    if (s1Fmt == FMT_BYTE)
      s1Index = vramRdData;
    else if (s1OddX)
      s1Index = {4'h0, vramRdData[7:4]};
    else
      s1Index = {4'h0, vramRdData[3:0]};
    s1Transp = (s1Index == 8'h00) ||
               ((s1Bank != '0) && (s1Index[3:0] == 4'h0));
    idxOff    = PAL_AW'({s1Index, {IDX_SH{1'b0}}});
    bankOff   = PAL_AW'({s1Bank, {BANK_SH{1'b0}}});
    palRdAddr = strobe.fetchPal ? s1Region + idxOff + bankOff : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      s2Transp <= 1'b0;
    else if (strobe.loadLookup)
      s2Transp <= s1Transp;
  end

  // stage 2: colour from palette data, top bit discarded
  always_comb begin
    outTransparent = resValid & s2Transp;
    outColour      = (resValid && !s2Transp) ? palRdData[COLOUR_W-1:0] : '0;
  end

endmodule

// File: rtl/tile_pixel_lookup.sv
module tile_pixel_lookup
  import tpl_pkg::*;
#(
  parameter int VRAM_AW  = 17,
  parameter int PAL_AW   = 10,
  parameter int COORD_W  = 3,
  parameter int BANK_W   = 4,
  parameter int COLOUR_W = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reqValid,
  input  logic [VRAM_AW-1:0]  reqBase,
  input  logic [COORD_W-1:0]  reqX,
  input  logic [COORD_W-1:0]  reqY,
  input  logic                reqFormat,
  input  logic [BANK_W-1:0]   reqBank,
  input  logic [PAL_AW-1:0]   reqRegion,
  output logic                vramRdEn,
  output logic [VRAM_AW-1:0]  vramRdAddr,
  input  logic [7:0]          vramRdData,
  output logic                palRdEn,
  output logic [PAL_AW-1:0]   palRdAddr,
  input  logic [15:0]         palRdData,
  output logic                outValid,
  output logic [COLOUR_W-1:0] outColour,
  output logic                outTransparent
);

  tpl_strobe_t strobe;
  logic        s1Transp;

  tpl_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .reqValid (reqValid),
    .s1Transp (s1Transp),
    .strobe   (strobe),
    .vramRdEn (vramRdEn),
    .palRdEn  (palRdEn),
    .outValid (outValid)
  );

  tpl_datapath #(
    .VRAM_AW (VRAM_AW),
    .PAL_AW  (PAL_AW),
    .COORD_W (COORD_W),
    .BANK_W  (BANK_W),
    .COLOUR_W(COLOUR_W)
  ) u_dp (
    .clk           (clk),
    .rst_n         (rst_n),
    .strobe        (strobe),
    .reqBase       (reqBase),
    .reqX          (reqX),
    .reqY          (reqY),
    .reqFormat     (reqFormat),
    .reqBank       (reqBank),
    .reqRegion     (reqRegion),
    .vramRdAddr    (vramRdAddr),
    .vramRdData    (vramRdData),
    .palRdAddr     (palRdAddr),
    .palRdData     (palRdData),
    .s1Transp      (s1Transp),
    .resValid      (outValid),
    .outColour     (outColour),
    .outTransparent(outTransparent)
  );

endmodule

// File: rtl/tpl_checker.sv
module tpl_checker #(
  parameter int COLOUR_W = 15
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reqValid,
  input logic                vramRdEn,
  input logic                palRdEn,
  input logic                outValid,
  input logic [COLOUR_W-1:0] outColour,
  input logic                outTransparent
);

  logic [1:0] sinceRst;

  always_ff @(posedge clk) begin
    if (!rst_n)
      sinceRst <= 2'd0;
    else if (sinceRst != 2'd3)
      sinceRst <= sinceRst + 2'd1;
  end

  // R2: result valid two edges after the request
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sinceRst >= 2'd2) |-> (outValid == $past(reqValid, 2)));

  // R2: a palette read is always preceded by a video read
  p_pal_after_vram_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((sinceRst >= 2'd1) && palRdEn) |-> $past(vramRdEn));

  // R7: a palette read always yields an opaque result
  p_pal_gives_opaque_r7: assert property (@(posedge clk) disable iff (!rst_n)
    palRdEn |=> (outValid && !outTransparent));

  // R7: transparent results carry a zero colour
  p_transp_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    outTransparent |-> (outValid && (outColour == '0)));

endmodule

bind tile_pixel_lookup tpl_checker #(.COLOUR_W(COLOUR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .reqValid      (reqValid),
  .vramRdEn      (vramRdEn),
  .palRdEn       (palRdEn),
  .outValid      (outValid),
  .outColour     (outColour),
  .outTransparent(outTransparent)
);

// File: tb/tile_pixel_lookup_tb.sv
module tile_pixel_lookup_tb;

  localparam int VAW = 17;
  localparam int PAW = 10;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           reqValid = 1'b0;
  logic [VAW-1:0] reqBase = '0;
  logic [2:0]     reqX = '0;
  logic [2:0]     reqY = '0;
  logic           reqFormat = 1'b0;
  logic [3:0]     reqBank = '0;
  logic [PAW-1:0] reqRegion = '0;
  logic           vramRdEn;
  logic [VAW-1:0] vramRdAddr;
  logic [7:0]     vramRdData = '0;
  logic           palRdEn;
  logic [PAW-1:0] palRdAddr;
  logic [15:0]    palRdData = '0;
  logic           outValid;
  logic [14:0]    outColour;
  logic           outTransparent;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  tile_pixel_lookup u_dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqBase(reqBase),
    .reqX(reqX), .reqY(reqY), .reqFormat(reqFormat), .reqBank(reqBank),
    .reqRegion(reqRegion), .vramRdEn(vramRdEn), .vramRdAddr(vramRdAddr),
    .vramRdData(vramRdData), .palRdEn(palRdEn), .palRdAddr(palRdAddr),
    .palRdData(palRdData), .outValid(outValid), .outColour(outColour),
    .outTransparent(outTransparent)
  );

  // memory models: low 256 video bytes hold their own address
  function automatic logic [7:0] vramByte(input logic [VAW-1:0] a);
    if (a[VAW-1:8] == '0) return a[7:0];
    return (a[7:0] * 8'd37) ^ a[15:8] ^ {7'd0, a[16]} ^ 8'h5B;
  endfunction

  function automatic logic [15:0] palWord(input logic [PAW-1:0] a);
    logic [14:0] v;
    v = (15'(a) * 15'd613) ^ 15'h2A55;
    return {1'b1, v};
  endfunction

  always @(posedge clk) begin
    if (vramRdEn) vramRdData <= vramByte(vramRdAddr);
    if (palRdEn)  palRdData  <= palWord(palRdAddr);
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  typedef struct {
    logic [VAW-1:0] vaddr;
    logic           transp;
    logic [PAW-1:0] paddr;
    logic [14:0]    colour;
  } exp_t;

  function automatic exp_t model(input logic [VAW-1:0] base, input int x, input int y,
                                 input bit wide, input int bank, input int region);
    exp_t e;
    logic [7:0] b;
    int idx;
    e.vaddr = wide ? base + VAW'(y*8 + x) : base + VAW'(y*4 + x/2);
    b = vramByte(e.vaddr);
    idx = wide ? int'(b) : ((x % 2 == 1) ? int'(b[7:4]) : int'(b[3:0]));
    e.transp = (idx == 0) || (bank != 0 && idx % 16 == 0);
    e.paddr  = PAW'(region + 2*idx + 32*bank);
    e.colour = e.transp ? 15'd0 : palWord(e.paddr)[14:0];
    return e;
  endfunction

  task automatic drive(input logic [VAW-1:0] base, input int x, input int y,
                       input bit wide, input int bank, input int region);
    reqValid  = 1'b1;
    reqBase   = base;
    reqX      = 3'(x);
    reqY      = 3'(y);
    reqFormat = wide;
    reqBank   = 4'(bank);
    reqRegion = PAW'(region);
  endtask

  // one isolated lookup, checking every port at its due cycle
  task automatic lookup(input string req, input logic [VAW-1:0] base, input int x,
                        input int y, input bit wide, input int bank, input int region);
    exp_t e;
    e = model(base, x, y, wide, bank, region);
    @(negedge clk);
    drive(base, x, y, wide, bank, region);
    #1;
    check(req, "vram strobe", 32'(vramRdEn), 32'd1);
    check(req, "vram address", 32'(vramRdAddr), 32'(e.vaddr));
    @(negedge clk);
    reqValid = 1'b0;
    check(req, "palette strobe", 32'(palRdEn), 32'(!e.transp));
    if (!e.transp) check(req, "palette address", 32'(palRdAddr), 32'(e.paddr));
    check(req, "early valid", 32'(outValid), 32'd0);
    @(negedge clk);
    check(req, "valid", 32'(outValid), 32'd1);
    check(req, "transparent", 32'(outTransparent), 32'(e.transp));
    check(req, "colour", 32'(outColour), 32'(e.colour));
  endtask

  task automatic testReset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "valid after reset", 32'(outValid), 32'd0);
    check("R1", "vram strobe after reset", 32'(vramRdEn), 32'd0);
    check("R1", "palette strobe after reset", 32'(palRdEn), 32'd0);
  endtask

  task automatic testIdle();
    reqValid = 1'b0;
    reqBase  = 17'h00040;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R10", "vram strobe idle", 32'(vramRdEn), 32'd0);
      check("R10", "valid idle", 32'(outValid), 32'd0);
    end
  endtask

  task automatic testBackToBack();
    exp_t q[3];
    q[0] = model(17'h1F000, 5, 6, 1'b1, 2, 64);
    q[1] = model(17'h00000, 0, 0, 1'b1, 0, 0);
    q[2] = model(17'h0A310, 3, 7, 1'b0, 1, 200);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        check("R2", "pipelined valid", 32'(outValid), 32'd1);
        check("R2", "pipelined transparent", 32'(outTransparent), 32'(q[i-2].transp));
        check("R2", "pipelined colour", 32'(outColour), 32'(q[i-2].colour));
      end
      case (i)
        0: drive(17'h1F000, 5, 6, 1'b1, 2, 64);
        1: drive(17'h00000, 0, 0, 1'b1, 0, 0);
        2: drive(17'h0A310, 3, 7, 1'b0, 1, 200);
        default: reqValid = 1'b0;
      endcase
    end
    @(negedge clk);
    check("R2", "valid drops after burst", 32'(outValid), 32'd0);
  endtask

  initial begin
    testReset();
    // R3 / R4: packed format, even and odd columns of byte 0x25
    lookup("R3", 17'h00020, 2, 1, 1'b0, 0, 0);
    lookup("R4", 17'h00020, 3, 1, 1'b0, 0, 0);
    lookup("R4", 17'h00030, 1, 0, 1'b0, 5, 8);
    // R5: byte format, whole byte as index
    lookup("R5", 17'h00040, 7, 2, 1'b1, 0, 16);
    // R6: bank and region offsets, including wrap
    lookup("R6", 17'h00060, 4, 3, 1'b1, 15, 900);
    // R7: zero index in both formats
    lookup("R7", 17'h00000, 0, 0, 1'b1, 0, 0);
    lookup("R7", 17'h00030, 0, 0, 1'b0, 3, 0);
    // R8: index 0x10 with a non-zero bank, then with bank 0
    lookup("R8", 17'h00000, 0, 2, 1'b1, 3, 0);
    lookup("R8", 17'h00000, 0, 2, 1'b1, 0, 0);
    // R9: palette words carry bit 15 set, colour keeps low bits
    lookup("R9", 17'h15A00, 6, 5, 1'b1, 1, 32);
    lookup("R9", 17'h0B7C4, 1, 4, 1'b0, 7, 512);
    testBackToBack();
    testIdle();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule